// File: doc/BRIEF.md
# Lane-Configurable SIMD Integer Adder

This unit adds or subtracts two 128-bit vector operands as a set of independent integer lanes. The lanes can be 8, 16, 32 or 64 bits wide. Each of the 16 vector registers has a 2-bit lane-width code, and all sixteen codes sit together in one 32-bit configuration word. The code of the destination register sets how the result is partitioned. The code of the source register sets how the second operand is read. No type tag is attached to the data. The same bits can be read at any width or signedness, depending only on the configuration word and the mode inputs.

When the two lane widths differ, the source operand is reshaped to fit the destination layout. A wider source lane is truncated to its low bits and fed into every destination lane that lies inside it. A narrower source is handled differently: the source lanes found in the lowest destination-lane-sized slice are reused in a rotating order (first, second, ... , first again) and each is zero- or sign-extended. A result style picks one of three behaviours: plain wraparound, add/subtract with a carry or borrow chained in per lane, or flagging of range overflow and underflow.

The processor supplies two register indices with their operand data, an add/subtract select and a one-cycle start strobe. The result and the per-lane flags appear, registered, one cycle after the start strobe, together with a one-cycle done pulse.

Top module: `simd_lane_adder`

## Requirements
- R1: The destination lane width comes from bits [2n+1:2n] of `lane_cfg`, where n is `dst_idx`, with the codes 00=8, 01=16, 10=32 and 11=64 bits. Lanes are computed independently and no carry crosses a lane boundary.
- R2: The source lane width comes from the `lane_cfg` field of `src_idx`. When the source lane is at least as wide as the destination lane, destination lane k uses the low bits of the source lane that contains bit k*Wd.
- R3: When the source lane is narrower, destination lane k uses source lane (k mod Wd/Ws), counted from bit 0. That lane is sign-extended when `is_signed`=1 and zero-extended otherwise.
- R4: For `arith_mode` 00 (wrap) or 11, each lane holds (a+b) or (a-b) modulo 2^Wd, and all flags are 0.
- R5: For `arith_mode` 01 (carry), an add produces a+b+cin. The lane's cin is the `carry_in` bit at the lane's lowest byte index, and the flag is the carry out of the lane.
- R6: In carry mode, a subtract produces a-b-bin, where bin is taken from `carry_in` as in R5. The flag is the borrow out (1 when a < b+bin).
- R7: For `arith_mode` 10 (overflow) with `is_signed`=0, the flag marks a result outside [0, 2^Wd-1]: a carry out on add, or a borrow on subtract. The result wraps.
- R8: In overflow mode with `is_signed`=1, the flag marks a two's-complement result outside [-2^(Wd-1), 2^(Wd-1)-1].
- R9: The flag of lane k sits at `flags` bit k*Wd/8. All other flag bits read 0.
- R10: `result` and `flags` update on the clock edge where `start` is sampled high and are visible after it. `done` is high for exactly that one cycle. Both outputs hold while `start` is low.
- R11: While reset is asserted, `result`, `flags` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_cfg | input | 32 | Packed 2-bit lane-width codes, one per register |
| is_signed | input | 1 | 1 = signed lane interpretation |
| arith_mode | input | 2 | 00 wrap, 01 carry, 10 overflow, 11 wrap |
| start | input | 1 | Begin an operation this cycle |
| sub | input | 1 | 1 = subtract source from destination |
| dst_idx | input | 4 | Destination register index |
| src_idx | input | 4 | Source register index |
| dst_data | input | 128 | Destination operand (first term) |
| src_data | input | 128 | Source operand (second term) |
| carry_in | input | 16 | Per-lane carry/borrow in, at lane's lowest byte bit |
| result | output | 128 | Registered lane results |
| flags | output | 16 | Registered per-lane carry, borrow or overflow flags |
| done | output | 1 | One-cycle pulse when result is valid |

## Verification
Bytes of all ones plus ones detect any carry that leaks across a lane boundary. Operands placed at the signed and unsigned range edges separate the carry flag from the two overflow flags. A 64-bit source over 8-bit destination lanes shows that the wide value is replicated into every covered lane. Narrow sources over 16- and 32-bit lanes show the rotating reuse of source lanes and the difference between sign and zero extension. A sweep with pseudo-random operands covers every pairing of destination and source width, every mode, both signedness settings and both operations, and compares the results with a lane-by-lane arithmetic model.

// File: rtl/simd_lane_adder.sv
module simd_lane_adder #(
  parameter int DATA_W = 128,
  parameter int NREG = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*NREG-1:0]         lane_cfg,
  input  logic                      is_signed,
  input  logic [1:0]                arith_mode,
  input  logic                      start,
  input  logic                      sub,
  input  logic [$clog2(NREG)-1:0]   dst_idx,
  input  logic [$clog2(NREG)-1:0]   src_idx,
  input  logic [DATA_W-1:0]         dst_data,
  input  logic [DATA_W-1:0]         src_data,
  input  logic [DATA_W/8-1:0]       carry_in,
  output logic [DATA_W-1:0]         result,
  output logic [DATA_W/8-1:0]       flags,
  output logic                      done
);
  localparam int NB = DATA_W / 8;
  localparam int IW = $clog2(DATA_W);
  localparam logic [1:0] M_CARRY = 2'b01;
  localparam logic [1:0] M_OVF   = 2'b10;

  logic [1:0]        wd_c, ws_c, wd_q, mode_q;
  logic [DATA_W-1:0] b_ext, b_inv, sum_c;
  logic [NB-1:0]     flag_c, unused_mask;

  assign wd_c = lane_cfg[{dst_idx, 1'b0} +: 2];
  assign ws_c = lane_cfg[{src_idx, 1'b0} +: 2];

  function automatic logic [DATA_W-1:0] expand(input logic [DATA_W-1:0] v,
                                               input logic [1:0] wsc,
                                               input logic [1:0] wdc,
                                               input logic sgn);
    int ws, wd, k, b, m;
    expand = '0;
    ws = 8 << wsc;
    wd = 8 << wdc;
    for (int i = 0; i < DATA_W; i++) begin
      k = i / wd;
      b = i % wd;
      if (ws >= wd) begin
        expand[i] = v[IW'(((k * wd) / ws) * ws + b)];
      end else begin
        m = k % (wd / ws);
        if (b < ws) expand[i] = v[IW'(m * ws + b)];
        else        expand[i] = sgn & v[IW'(m * ws + ws - 1)];
      end
    end
  endfunction

  assign b_ext = expand(src_data, ws_c, wd_c, is_signed);
  assign b_inv = sub ? ~b_ext : b_ext;

  always_comb begin
    logic c;
    logic lane_cin;
    int   bpl;
    sum_c    = '0;
    flag_c   = '0;
    c        = 1'b0;
    lane_cin = 1'b0;
    bpl      = 1 << wd_c;
    for (int i = 0; i < NB; i++) begin
      if (i % bpl == 0) begin
        lane_cin = (arith_mode == M_CARRY) & carry_in[i];
        c = sub ? ~lane_cin : lane_cin;
      end
      {c, sum_c[i*8 +: 8]} = {1'b0, dst_data[i*8 +: 8]} + {1'b0, b_inv[i*8 +: 8]} + {8'd0, c};
      if (i % bpl == bpl - 1) begin
        if (arith_mode == M_CARRY || (arith_mode == M_OVF && !is_signed))
          flag_c[i-bpl+1] = c ^ sub;
        else if (arith_mode == M_OVF)
          flag_c[i-bpl+1] = (dst_data[i*8+7] == b_inv[i*8+7]) &&
                            (sum_c[i*8+7] != dst_data[i*8+7]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flags  <= '0;
      done   <= 1'b0;
      wd_q   <= 2'b00;
      mode_q <= 2'b00;
    end else begin
      done <= start;
      if (start) begin
        result <= sum_c;
        flags  <= flag_c;
        wd_q   <= wd_c;
        mode_q <= arith_mode;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < NB; j++) unused_mask[j] = (j % (1 << wd_q)) != 0;
  end

  // R10: a start strobe is answered by done on the next cycle
  p_start_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R10: done never appears without a start one cycle earlier
  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  // R10: outputs hold while no operation is started
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(flags)));
  // R9: only the lowest flag bit of each lane may be set
  p_flag_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((flags & unused_mask) == '0));
  // R4: wrap style never raises a flag
  p_wrap_noflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q == 2'b00 || mode_q == 2'b11)) |-> (flags == '0));
endmodule

// File: tb/simd_lane_adder_test.sv
`timescale 1ns/1ps
module simd_lane_adder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  lane_cfg = '0;
  logic         is_signed = 1'b0;
  logic [1:0]   arith_mode = 2'b00;
  logic         start = 1'b0;
  logic         sub = 1'b0;
  logic [3:0]   dst_idx = 4'd5;
  logic [3:0]   src_idx = 4'd9;
  logic [127:0] dst_data = '0;
  logic [127:0] src_data = '0;
  logic [15:0]  carry_in = '0;
  logic [127:0] result;
  logic [15:0]  flags;
  logic         done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  simd_lane_adder uut (
    .clk(clk), .rst_n(rst_n), .lane_cfg(lane_cfg), .is_signed(is_signed),
    .arith_mode(arith_mode), .start(start), .sub(sub), .dst_idx(dst_idx),
    .src_idx(src_idx), .dst_data(dst_data), .src_data(src_data),
    .carry_in(carry_in), .result(result), .flags(flags), .done(done)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [65:0] msk(input int w);
    return (66'd1 << w) - 66'd1;
  endfunction

  function automatic logic [65:0] lane(input logic [127:0] v, input int off, input int w);
    logic [127:0] t;
    t = v >> off;
    return t[65:0] & msk(w);
  endfunction

  function automatic void model(input logic [127:0] a_v, input logic [127:0] b_v,
                                input int wdc, input int wsc, input bit sgn,
                                input int mode, input bit sb, input logic [15:0] cin,
                                output logic [127:0] res, output logic [15:0] flg);
    int wd, ws;
    logic [65:0] a, b, r, sa, sbv, rs;
    logic cb, f;
    wd = 8 << wdc;
    ws = 8 << wsc;
    res = '0;
    flg = '0;
    for (int k = 0; k < 128 / wd; k++) begin
      a = lane(a_v, k * wd, wd);
      if (ws >= wd) b = lane(b_v, ((k * wd) / ws) * ws, wd);
      else begin
        b = lane(b_v, (k % (wd / ws)) * ws, ws);
        if (sgn && b[ws-1]) b = b | (msk(wd) & ~msk(ws));
      end
      cb = (mode == 1) ? cin[k * wd / 8] : 1'b0;
      r = sb ? (a - b - {65'd0, cb}) : (a + b + {65'd0, cb});
      sa = a[wd-1] ? (a | ~msk(wd)) : a;
      sbv = b[wd-1] ? (b | ~msk(wd)) : b;
      rs = sb ? (sa - sbv) : (sa + sbv);
      if (mode == 1) f = r[wd];
      else if (mode == 2) f = sgn ? (rs[wd] != rs[wd-1]) : r[wd];
      else f = 1'b0;
      res = res | ({62'd0, r & msk(wd)} << (k * wd));
      flg[k * wd / 8] = f;
    end
  endfunction

  task automatic run(input int wdc, input int wsc, input bit sgn, input int mode,
                     input bit sb, input logic [127:0] a, input logic [127:0] b,
                     input logic [15:0] cin);
    @(negedge clk);
    lane_cfg = 32'hA5C3_96F0;
    lane_cfg[2*dst_idx +: 2] = wdc[1:0];
    lane_cfg[2*src_idx +: 2] = wsc[1:0];
    is_signed = sgn;
    arith_mode = mode[1:0];
    sub = sb;
    dst_data = a;
    src_data = b;
    carry_in = cin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [127:0] r, input logic [15:0] f);
    chk({req, " result"}, result, r);
    chk({req, " flags"}, {112'd0, flags}, {112'd0, f});
  endtask

  task automatic t_reset;
    chk("R11 result", result, '0);
    chk("R11 flags", {112'd0, flags}, '0);
    chk("R11 done", {127'd0, done}, '0);
  endtask

  task automatic t_lane_isolation;
    run(0, 0, 0, 0, 0, {16{8'hFF}}, {16{8'h01}}, '0);
    expect_out("R1 R4 byte lanes isolated", '0, '0);
    run(1, 1, 0, 3, 1, {8{16'h0000}}, {8{16'h0001}}, '0);
    expect_out("R4 mode 11 wrap sub", {8{16'hFFFF}}, '0);
  endtask

  task automatic t_carry;
    run(1, 1, 0, 1, 0, {8{16'hFFFF}}, '0, 16'hFFFF);
    expect_out("R5 R9 carry add", '0, 16'h5555);
    run(2, 2, 1, 1, 1, '0, '0, 16'h0001);
    expect_out("R6 borrow sub", {96'd0, 32'hFFFF_FFFF}, 16'h0001);
  endtask

  task automatic t_overflow;
    run(3, 3, 1, 2, 0, {64'h7FFF_FFFF_FFFF_FFFF, 64'h1}, {64'h1, 64'h1}, '0);
    expect_out("R8 signed add overflow", {64'h8000_0000_0000_0000, 64'h2}, 16'h0100);
    run(0, 0, 0, 2, 1, {16{8'h05}}, {16{8'h06}}, '0);
    expect_out("R7 unsigned underflow", {16{8'hFF}}, 16'hFFFF);
    run(0, 0, 1, 2, 1, {16{8'h05}}, {16{8'h06}}, '0);
    expect_out("R8 signed no overflow", {16{8'hFF}}, 16'h0000);
  endtask

  task automatic t_wide_source;
    run(0, 3, 0, 0, 0, '0, {{8{8'h11}}, 64'h0000_0000_0000_0042}, '0);
    expect_out("R2 wide source broadcast", {{8{8'h11}}, {8{8'h42}}}, '0);
  endtask

  task automatic t_narrow_source;
    run(2, 0, 0, 0, 0, '0, {{12{8'hEE}}, 32'h8003_0201}, '0);
    expect_out("R3 cyclic zero extend", {32'h80, 32'h3, 32'h2, 32'h1}, '0);
    run(2, 0, 1, 0, 0, '0, {{12{8'hEE}}, 32'h8003_0201}, '0);
    expect_out("R3 cyclic sign extend", {32'hFFFF_FF80, 32'h3, 32'h2, 32'h1}, '0);
    run(1, 0, 0, 0, 0, '0, {{14{8'hEE}}, 16'h0201}, '0);
    expect_out("R3 cyclic repeat", {4{16'h0002, 16'h0001}}, '0);
  endtask

  task automatic t_timing;
    logic [127:0] held;
    @(negedge clk);
    lane_cfg = '0;
    arith_mode = 2'b00;
    sub = 1'b0;
    dst_data = 128'h1;
    src_data = 128'h2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 done raised", {127'd0, done}, 128'd1);
    chk("R10 result valid", result, 128'h3);
    held = result;
    dst_data = 128'h55;
    @(negedge clk);
    chk("R10 done one cycle", {127'd0, done}, '0);
    chk("R10 result held", result, held);
  endtask

  task automatic t_sweep;
    logic [127:0] a, b, er;
    logic [15:0] ef, c;
    for (int wd = 0; wd < 4; wd++)
      for (int ws = 0; ws < 4; ws++)
        for (int md = 0; md < 4; md++)
          for (int sg = 0; sg < 2; sg++)
            for (int sb = 0; sb < 2; sb++) begin
              a = {$urandom, $urandom, $urandom, $urandom};
              b = {$urandom, $urandom, $urandom, $urandom};
              c = 16'($urandom);
              model(a, b, wd, ws, sg[0], md, sb[0], c, er, ef);
              run(wd, ws, sg[0], md, sb[0], a, b, c);
              expect_out("R1 R2 R3 R4 R5 R6 R7 R8 sweep", er, ef);
            end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lane_isolation();
    t_carry();
    t_overflow();
    t_wide_source();
    t_narrow_source();
    t_timing();
    t_sweep();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule